// File: doc/BRIEF.md
# Unbuffered Serial Shift Data Register

This block is a parallel-access shift register that a host reads and writes directly. There is no holding buffer between the host port and the shifter. A read always returns the live shift contents. A write replaces them at once. On each selected shift strobe the contents move one place toward the MSB, and the serial input pin fills the LSB.

A 2-bit source field picks what produces the strobe:

| Field value | Strobe source |
|-------------|---------------|
| 00 | A single-cycle software strobe input |
| 01 | A timer compare-match pulse |
| 10 | An external serial clock, rising edge active |
| 11 | An external serial clock, falling edge active |

The serial clock pin is synchronised into the system clock domain before its edges are detected. The serial clock and data pins feed the shifter whatever line mode the surrounding logic has chosen.

The MSB reaches the data output pin through an output latch. With an internal source (field bit 1 = 0) the latch is always transparent. With an external source the latch closes on the active (sampling) edge and reopens on the opposite edge. Sampling and output changes therefore fall on opposite serial clock edges.

Top module: `usr_shift_reg`

## Requirements
- R1: After reset the register reads 0x00 and the data output is 0.
- R2: A host write loads the written value, and the read port returns it from the next clock on with no extra latency.
- R3: A shift strobe changes the contents to {contents[WIDTH-2:0], din}.
- R4: When a host write and a shift strobe occur in the same cycle, the register takes the written value and the shift is dropped.
- R5: With source field 00 the software strobe shifts. Timer pulses and serial clock edges are ignored.
- R6: With source field 01 a timer compare-match pulse shifts. Software strobes and serial clock edges are ignored.
- R7: With source field 10 a serial clock rising edge shifts and a falling edge does not; with 11 it is the other way round. The shift is visible on the read port by the fourth system clock edge after the pin changes (two synchroniser stages plus one edge register).
- R8: With field bit 1 = 0, the data output equals the register MSB in every cycle, including right after a host write.
- R9: With field bit 1 = 1, on the active edge the output latches the MSB value held just before that shift. It keeps that value, ignoring shifts and host writes, until the inactive edge is detected.
- R10: With field bit 1 = 1 and the latch open (after reset or after an inactive edge), a host write of a new MSB appears on the output in the cycle the register updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write enable |
| wr_data_i | input | WIDTH | Host write data |
| rd_data_o | output | WIDTH | Live shift register contents |
| clk_sel_i | input | 2 | Strobe source: 00 soft, 01 timer, 10 ext rising, 11 ext falling |
| sw_strobe_i | input | 1 | Single-cycle software shift strobe |
| tmr_match_i | input | 1 | Timer compare-match pulse |
| sclk_i | input | 1 | External serial clock pin (asynchronous) |
| din_i | input | 1 | Serial data input into the LSB |
| dout_o | output | 1 | Serial data output from the MSB via the output latch |

## Verification
Host writes and internal strobes take effect on the clock edge that samples them. The bench drives those inputs on a falling system clock edge and reads the result on the following falling edge.

A serial clock pin change passes through two synchroniser flops and one edge register before the shift lands. The bench therefore waits four system clock periods after each pin change before comparing the read port and the output pin.

The internal-mode output follows the MSB within the same cycle as the register. The latched output is compared both while the latch holds and after the reopening edge has been processed.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    SRC_SOFT     = 2'b00,
    SRC_TIMER    = 2'b01,
    SRC_EXT_RISE = 2'b10,
    SRC_EXT_FALL = 2'b11
  } strobe_src_e;

  // Source field bit 1 marks the external serial clock.
  function automatic logic is_external(input strobe_src_e src);
    return src[1];
  endfunction

endpackage

// File: rtl/usr_sync_edge.sv
module usr_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[LAST];
  end

  assign rise_o = chain_q[LAST] & ~prev_q;
  assign fall_o = ~chain_q[LAST] & prev_q;

  // R7: an edge lasts exactly one cycle.
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
  a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/usr_strobe_sel.sv
module usr_strobe_sel
  import usr_pkg::*;
(
  input  logic [1:0] clk_sel_i,
  input  logic       sw_i,
  input  logic       tmr_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       ext_o,
  output logic       shift_o,
  output logic       close_o,
  output logic       open_o
);
  strobe_src_e src;
  logic        act_edge, inact_edge;

  always_comb begin
    src        = strobe_src_e'(clk_sel_i);
    act_edge   = (src == SRC_EXT_FALL) ? fall_i : rise_i;
    inact_edge = (src == SRC_EXT_FALL) ? rise_i : fall_i;
    ext_o      = is_external(src);
    unique case (src)
      SRC_SOFT:  shift_o = sw_i;
      SRC_TIMER: shift_o = tmr_i;
      default:   shift_o = act_edge;
    endcase
    close_o = ext_o & act_edge;
    open_o  = ext_o & inact_edge;
  end

endmodule

// File: rtl/usr_out_latch.sv
module usr_out_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  input  logic close_i,
  input  logic open_i,
  input  logic msb_i,
  output logic dout_o
);
  logic open_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b1;
      hold_q <= 1'b0;
    end else if (close_i) begin
      open_q <= 1'b0;
      hold_q <= msb_i;
    end else if (open_i) begin
      open_q <= 1'b1;
    end
  end

  assign dout_o = (!ext_i || open_q) ? msb_i : hold_q;

  // R9: while closed in external mode, the output does not move.
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_i && !open_q && !open_i && !close_i) |=> (!ext_i || $stable(dout_o)));
  // R9: a closing edge captures the MSB that was present before it.
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_i && close_i) |=> (!ext_i || dout_o == $past(msb_i)));

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic [1:0]       clk_sel_i,
  input  logic             sw_strobe_i,
  input  logic             tmr_match_i,
  input  logic             sclk_i,
  input  logic             din_i,
  output logic             dout_o
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] shift_in(input logic [WIDTH-1:0] cur,
                                                input logic bit_in);
    return {cur[WIDTH-2:0], bit_in};
  endfunction

  logic [WIDTH-1:0] sreg_q;
  logic rise_w, fall_w, ext_w, shift_w, close_w, open_w;

  usr_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (sclk_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  usr_strobe_sel u_sel (
    .clk_sel_i (clk_sel_i),
    .sw_i      (sw_strobe_i),
    .tmr_i     (tmr_match_i),
    .rise_i    (rise_w),
    .fall_i    (fall_w),
    .ext_o     (ext_w),
    .shift_o   (shift_w),
    .close_o   (close_w),
    .open_o    (open_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg_q <= '0;
    else if (wr_en_i) sreg_q <= wr_data_i;
    else if (shift_w) sreg_q <= shift_in(sreg_q, din_i);
  end

  assign rd_data_o = sreg_q;

  usr_out_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_i   (ext_w),
    .close_i (close_w),
    .open_i  (open_w),
    .msb_i   (sreg_q[MSB]),
    .dout_o  (dout_o)
  );

  // R4: a write always wins.
  a_r4_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> rd_data_o == $past(wr_data_i));
  // R3: a strobe without a write shifts left with din into the LSB.
  a_r3_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_w && !wr_en_i) |=> rd_data_o == {$past(rd_data_o[WIDTH-2:0]), $past(din_i)});
  // R5/R6: no write and no strobe leaves the contents alone.
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_w && !wr_en_i) |=> $stable(rd_data_o));
  // R8: the internal-mode output tracks the MSB.
  a_r8_internal_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_sel_i[1] |-> dout_o == rd_data_o[MSB]);

endmodule

// File: tb/tb_usr_shift_reg.sv
module tb_usr_shift_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] csel = 2'b00;
  logic       sw = 1'b0, tmr = 1'b0, sclk = 1'b0, din = 1'b0;
  logic       dout;
  int nchk = 0, nerr = 0;
  logic [7:0] exp;

  always #5 clk = ~clk;

  usr_shift_reg #(.WIDTH(8), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .clk_sel_i(csel), .sw_strobe_i(sw),
    .tmr_match_i(tmr), .sclk_i(sclk), .din_i(din), .dout_o(dout)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] want);
    nchk++;
    if (got !== want) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", tag, got, want);
    end
  endtask

  task automatic host_wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic t, input logic w,
                       input logic [7:0] v, input logic d);
    @(negedge clk); sw = s; tmr = t; wr_en = w; wr_data = v; din = d;
    @(negedge clk); sw = 1'b0; tmr = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_sclk(input logic v);
    @(negedge clk); sclk = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset data", rd_data, 8'h00);
    chk("R1 reset dout", {7'd0, dout}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R8: every value round-trips, output follows MSB
    for (int v = 0; v < 256; v++) begin
      host_wr(v[7:0]);
      chk("R2 readback", rd_data, v[7:0]);
      chk("R8 dout msb", {7'd0, dout}, {7'd0, v[7]});
    end

    // R3 / R5: software shifts with several patterns; timer ignored
    csel = 2'b00;
    for (int p = 0; p < 16; p++) begin
      exp = 8'(p * 37 + 11);
      host_wr(exp);
      for (int k = 0; k < 8; k++) begin
        logic b;
        b = ((p >> (k % 4)) & 1) != 0;
        pulse(1'b1, 1'b0, 1'b0, 8'h00, b);
        exp = {exp[6:0], b};
        chk("R3 R5 soft shift", rd_data, exp);
      end
      pulse(1'b0, 1'b1, 1'b0, 8'h00, 1'b1);
      chk("R5 timer ignored", rd_data, exp);
    end
    set_sclk(1'b1); set_sclk(1'b0);
    chk("R5 sclk ignored", rd_data, exp);

    // R6: timer shifts, software ignored
    csel = 2'b01;
    host_wr(8'h3C); exp = 8'h3C;
    for (int k = 0; k < 6; k++) begin
      pulse(1'b0, 1'b1, 1'b0, 8'h00, k[0]);
      exp = {exp[6:0], k[0]};
      chk("R6 timer shift", rd_data, exp);
    end
    pulse(1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
    chk("R6 soft ignored", rd_data, exp);
    set_sclk(1'b1); set_sclk(1'b0);
    chk("R6 sclk ignored", rd_data, exp);

    // R4: write with a simultaneous strobe
    pulse(1'b0, 1'b1, 1'b1, 8'h96, 1'b1);
    chk("R4 write wins", rd_data, 8'h96);
    csel = 2'b00;
    pulse(1'b1, 1'b0, 1'b1, 8'h5A, 1'b1);
    chk("R4 write wins soft", rd_data, 8'h5A);

    // R7 / R9 / R10: rising edge active
    csel = 2'b10;
    sclk = 1'b0; repeat (4) @(negedge clk);
    host_wr(8'h80);
    chk("R10 open shows msb", {7'd0, dout}, 8'h01);
    exp = 8'h80;
    din = 1'b0;
    set_sclk(1'b1);
    exp = {exp[6:0], 1'b0};
    chk("R7 rise shifts", rd_data, exp);
    chk("R9 held msb", {7'd0, dout}, 8'h01);
    host_wr(8'h00);
    chk("R9 write hidden", {7'd0, dout}, 8'h01);
    set_sclk(1'b0);
    chk("R7 fall no shift", rd_data, 8'h00);
    chk("R9 reopen", {7'd0, dout}, 8'h00);
    host_wr(8'h81);
    chk("R10 write visible", {7'd0, dout}, 8'h01);
    exp = 8'h81;
    pulse(1'b1, 1'b1, 1'b0, 8'h00, 1'b1);
    chk("R7 internal strobes ignored", rd_data, exp);
    for (int k = 0; k < 8; k++) begin
      din = k[1];
      set_sclk(1'b1);
      exp = {exp[6:0], k[1]};
      chk("R7 rise sweep", rd_data, exp);
      set_sclk(1'b0);
      chk("R7 fall sweep", rd_data, exp);
      chk("R9 dout after reopen", {7'd0, dout}, {7'd0, exp[7]});
    end

    // R7: falling edge active
    csel = 2'b11;
    sclk = 1'b1; repeat (4) @(negedge clk);
    host_wr(8'hC3); exp = 8'hC3;
    for (int k = 0; k < 8; k++) begin
      logic m;
      din = ~k[0];
      m = exp[7];
      set_sclk(1'b0);
      exp = {exp[6:0], ~k[0]};
      chk("R7 fall active", rd_data, exp);
      chk("R9 hold on fall", {7'd0, dout}, {7'd0, m});
      set_sclk(1'b1);
      chk("R7 rise inactive", rd_data, exp);
      chk("R10 open after rise", {7'd0, dout}, {7'd0, exp[7]});
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule